// File: doc/BRIEF.md
# Compressed Control-Transfer Next-PC Unit

This block resolves the 16-bit control-transfer operations of a 32-bit core. Each cycle it takes a valid strobe, an operation code, the address of the current instruction, the value read from the first source register and an already decoded, sign-extended offset. One clock later it presents the address to fetch next, a taken flag that the fetch logic uses to flush, and a request to write the return address into a register.

Because the instructions are two bytes wide, the sequential address and the return address are both the current address plus 2. Register-indirect jumps force bit 0 of the target low. The unconditional jump without link uses the same path as the jump with link, and its link index is register 0, so no register is written. An optional flag marks a PC-relative target that is odd.

Top module: `cjmp_unit`

## Requirements
- R1: While reset is held low, every output is zero.
- R2: For a valid branch-if-zero (op=1) with a source value of zero, taken is 1 and the next PC is PC plus the signed offset.
- R3: For a valid branch-if-not-zero (op=2) with a non-zero source value, taken is 1 and the next PC is PC plus the signed offset.
- R4: A valid branch (op=1 or op=2) whose condition fails gives taken 0 and a next PC of PC+2, wrapping modulo 2^32.
- R5: A valid jump-and-link (op=4) gives taken 1, a next PC of PC plus the offset, a link write enable of 1 and a link index of 1. The link value is PC+2 for every operation.
- R6: A valid plain jump (op=3) gives taken 1 and a next PC of PC plus the offset, with link index 0 and the link write enable low.
- R7: A valid register jump (op=5) gives taken 1 and a next PC equal to the source value with bit 0 cleared. The link write enable is low and the link index is 0.
- R8: A valid register jump-and-link (op=6) gives taken 1, a next PC equal to the source value with bit 0 cleared, a link write enable of 1 and a link index of 1.
- R9: When valid is low, or the op is 0 or 7, the next PC is PC+2, taken is 0, the link write enable is 0 and the link index is 0.
- R10: The misaligned flag is 1 only when a taken PC-relative target (op 1, 2, 3 or 4) has bit 0 set. It stays 0 for ops 5 and 6, even when the source value is odd.
- R11: All outputs are registered. The output valid equals the input valid of the previous cycle, and back-to-back operations produce back-to-back results.
- R12: The link write enable is never 1 while the link index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code: 0 none, 1 branch-if-zero, 2 branch-if-not-zero, 3 jump, 4 jump-and-link, 5 register jump, 6 register jump-and-link, 7 none |
| in_pc | input | 32 | Address of the current instruction |
| in_rs1 | input | 32 | Source register value |
| in_offset | input | 32 | Sign-extended PC-relative offset |
| out_valid | output | 1 | Registered copy of in_valid |
| out_next_pc | output | 32 | Address to fetch next |
| out_taken | output | 1 | Control flow was redirected |
| out_link_we | output | 1 | Write the return address |
| out_link_idx | output | 5 | Destination register of the return address |
| out_link_val | output | 32 | Return address, PC+2 |
| out_misalign | output | 1 | Taken PC-relative target is odd |

## Verification
The bench drives branches at the edge of their condition: a zero source, a source with only the top bit set, and a negative offset. A unit that tested only the low bits, or that added the offset without sign extension, would send the fetch to the wrong address. Register jumps use odd source values. A design that kept bit 0 would emit an odd PC, and one that computed the odd check from the wrong target would raise a false misaligned flag. A not-taken branch at address 0xFFFFFFFE checks that the sequential step is 2 rather than 4 and that it wraps. The plain jump and the invalid or reserved ops check that no link write leaks through when the index is zero or the operation was never issued.

// File: rtl/cjmp_pkg.sv
package cjmp_pkg;

    typedef enum logic [2:0] {
        CJ_NOP  = 3'd0,
        CJ_BEQZ = 3'd1,
        CJ_BNEZ = 3'd2,
        CJ_J    = 3'd3,
        CJ_JAL  = 3'd4,
        CJ_JR   = 3'd5,
        CJ_JALR = 3'd6,
        CJ_RSV  = 3'd7
    } cj_op_e;

endpackage

// File: rtl/cjmp_cond.sv
// Decides whether the operation redirects flow and which target form it uses.
module cjmp_cond
    import cjmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cj_op_e            op,
    input  logic [XLEN-1:0]   rs1,
    output logic              take,
    output logic              indirect
);
    logic rs1_zero;

    assign rs1_zero = (rs1 == '0);

    always_comb begin
        take     = 1'b0;
        indirect = 1'b0;
        case (op)
            CJ_BEQZ: take = rs1_zero;
            CJ_BNEZ: take = !rs1_zero;
            CJ_J,
            CJ_JAL:  take = 1'b1;
            CJ_JR,
            CJ_JALR: begin
                take     = 1'b1;
                indirect = 1'b1;
            end
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/cjmp_target.sv
// Computes the sequential, PC-relative and register-indirect addresses in parallel.
module cjmp_target #(
    parameter int XLEN        = 32,
    parameter int INSN_BYTES  = 2,
    parameter bit EN_MISALIGN = 1'b1
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] rel_tgt,
    output logic [XLEN-1:0] ind_tgt,
    output logic            rel_odd
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    assign seq_pc  = pc + STEP;
    assign rel_tgt = pc + offset;
    assign ind_tgt = {rs1[XLEN-1:1], 1'b0};

    generate
        if (EN_MISALIGN) begin : g_odd
            assign rel_odd = rel_tgt[0];
        end else begin : g_no_odd
            assign rel_odd = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cjmp_link.sv
// Selects the return-address destination; a zero index suppresses the write.
module cjmp_link
    import cjmp_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int LINK_REG = 1
) (
    input  cj_op_e            op,
    output logic [REG_W-1:0]  idx,
    output logic              we
);
    localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

    always_comb begin
        case (op)
            CJ_JAL,
            CJ_JALR: idx = LINK_IDX;
            default: idx = '0;
        endcase
    end

    assign we = (idx != '0);
endmodule

// File: rtl/cjmp_unit.sv
module cjmp_unit
    import cjmp_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int REG_W       = 5,
    parameter int LINK_REG    = 1,
    parameter int INSN_BYTES  = 2,
    parameter bit EN_MISALIGN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [XLEN-1:0]  in_pc,
    input  logic [XLEN-1:0]  in_rs1,
    input  logic [XLEN-1:0]  in_offset,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_next_pc,
    output logic             out_taken,
    output logic             out_link_we,
    output logic [REG_W-1:0] out_link_idx,
    output logic [XLEN-1:0]  out_link_val,
    output logic             out_misalign
);
    typedef struct packed {
        logic             valid;
        logic [XLEN-1:0]  next_pc;
        logic             taken;
        logic             link_we;
        logic [REG_W-1:0] link_idx;
        logic [XLEN-1:0]  link_val;
        logic             misalign;
    } res_t;

    res_t   res_d, res_q;
    cj_op_e op;

    logic             take, indirect, rel_odd, lnk_we;
    logic [XLEN-1:0]  seq_pc, rel_tgt, ind_tgt;
    logic [REG_W-1:0] lnk_idx;

    assign op = cj_op_e'(in_op);

    cjmp_cond #(.XLEN(XLEN)) u_cond (
        .op       (op),
        .rs1      (in_rs1),
        .take     (take),
        .indirect (indirect)
    );

    cjmp_target #(
        .XLEN        (XLEN),
        .INSN_BYTES  (INSN_BYTES),
        .EN_MISALIGN (EN_MISALIGN)
    ) u_target (
        .pc      (in_pc),
        .rs1     (in_rs1),
        .offset  (in_offset),
        .seq_pc  (seq_pc),
        .rel_tgt (rel_tgt),
        .ind_tgt (ind_tgt),
        .rel_odd (rel_odd)
    );

    cjmp_link #(.REG_W(REG_W), .LINK_REG(LINK_REG)) u_link (
        .op  (op),
        .idx (lnk_idx),
        .we  (lnk_we)
    );

    always_comb begin
        res_d          = '0;
        res_d.valid    = in_valid;
        res_d.next_pc  = seq_pc;
        res_d.link_val = seq_pc;
        if (in_valid) begin
            res_d.link_idx = lnk_idx;
            res_d.link_we  = lnk_we;
            if (take) begin
                res_d.taken    = 1'b1;
                res_d.next_pc  = indirect ? ind_tgt : rel_tgt;
                res_d.misalign = !indirect && rel_odd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid    = res_q.valid;
    assign out_next_pc  = res_q.next_pc;
    assign out_taken    = res_q.taken;
    assign out_link_we  = res_q.link_we;
    assign out_link_idx = res_q.link_idx;
    assign out_link_val = res_q.link_val;
    assign out_misalign = res_q.misalign;
endmodule

// File: rtl/cjmp_unit_chk.sv
module cjmp_unit_chk
    import cjmp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_op,
    input logic [XLEN-1:0]  in_pc,
    input logic [XLEN-1:0]  in_rs1,
    input logic             out_valid,
    input logic [XLEN-1:0]  out_next_pc,
    input logic             out_taken,
    input logic             out_link_we,
    input logic [REG_W-1:0] out_link_idx,
    input logic [XLEN-1:0]  out_link_val,
    input logic             out_misalign
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                                // R11
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_taken && !out_link_we));              // R9
    AST_LINK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_link_we |-> (out_link_idx != '0));                                  // R12
    AST_BEQZ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == CJ_BEQZ && in_rs1 != '0)
        |=> (!out_taken && out_next_pc == $past(in_pc) + XLEN'(2)));            // R4
    AST_IND_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == CJ_JR || in_op == CJ_JALR))
        |=> (out_taken && !out_next_pc[0] && !out_misalign));                   // R7
    AST_JALR_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == CJ_JALR)
        |=> (out_link_we && out_link_idx == REG_W'(1)
             && out_link_val == $past(in_pc) + XLEN'(2)));                      // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && !out_taken && !out_link_we));                 // R1
endmodule

bind cjmp_unit cjmp_unit_chk #(.XLEN(XLEN), .REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_op        (in_op),
    .in_pc        (in_pc),
    .in_rs1       (in_rs1),
    .out_valid    (out_valid),
    .out_next_pc  (out_next_pc),
    .out_taken    (out_taken),
    .out_link_we  (out_link_we),
    .out_link_idx (out_link_idx),
    .out_link_val (out_link_val),
    .out_misalign (out_misalign)
);

// File: tb/tb_cjmp_unit.sv
module tb_cjmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'd0;
    logic [31:0] in_pc = '0, in_rs1 = '0, in_offset = '0;
    logic        out_valid, out_taken, out_link_we, out_misalign;
    logic [31:0] out_next_pc, out_link_val;
    logic [4:0]  out_link_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic        v;
        logic [31:0] npc;
        logic        tk;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] lval;
        logic        mis;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    cjmp_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_pc(in_pc), .in_rs1(in_rs1), .in_offset(in_offset),
        .out_valid(out_valid), .out_next_pc(out_next_pc), .out_taken(out_taken),
        .out_link_we(out_link_we), .out_link_idx(out_link_idx),
        .out_link_val(out_link_val), .out_misalign(out_misalign)
    );

    function automatic exp_t model(input bit v, input logic [2:0] op,
                                   input logic [31:0] pc, input logic [31:0] rs1,
                                   input logic [31:0] off, input string tag);
        exp_t e;
        logic [31:0] rel;
        bit branch_ok;
        rel    = pc + off;
        e.v    = v;
        e.npc  = pc + 32'd2;
        e.lval = pc + 32'd2;
        e.tk   = 1'b0;
        e.we   = 1'b0;
        e.idx  = 5'd0;
        e.mis  = 1'b0;
        e.tag  = tag;
        if (v) begin
            branch_ok = (op == 3'd1 && rs1 == 0) || (op == 3'd2 && rs1 != 0);
            if (branch_ok || op == 3'd3 || op == 3'd4) begin
                e.tk  = 1'b1;
                e.npc = rel;
                e.mis = rel[0];
            end
            if (op == 3'd5 || op == 3'd6) begin
                e.tk  = 1'b1;
                e.npc = rs1 & 32'hFFFF_FFFE;
            end
            if (op == 3'd4 || op == 3'd6) begin
                e.we  = 1'b1;
                e.idx = 5'd1;
            end
        end
        return e;
    endfunction

    task automatic drive(input bit v, input logic [2:0] op, input logic [31:0] pc,
                         input logic [31:0] rs1, input logic [31:0] off,
                         input string tag);
        @(negedge clk);
        in_valid  = v;
        in_op     = op;
        in_pc     = pc;
        in_rs1    = rs1;
        in_offset = off;
        sb.push_back(model(v, op, pc, rs1, off, tag));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // monitor: result of the operation driven before this edge is compared 2 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (out_valid !== e.v || out_next_pc !== e.npc || out_taken !== e.tk ||
                    out_link_we !== e.we || out_link_idx !== e.idx ||
                    out_link_val !== e.lval || out_misalign !== e.mis) begin
                    n_bad++;
                    $display("FAIL %s: actual v=%0b npc=%h tk=%0b we=%0b idx=%0d lval=%h mis=%0b expected v=%0b npc=%h tk=%0b we=%0b idx=%0d lval=%h mis=%0b",
                             e.tag, out_valid, out_next_pc, out_taken, out_link_we,
                             out_link_idx, out_link_val, out_misalign,
                             e.v, e.npc, e.tk, e.we, e.idx, e.lval, e.mis);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++; // R1 reset state
        if (out_valid !== 1'b0 || out_next_pc !== '0 || out_taken !== 1'b0 ||
            out_link_we !== 1'b0 || out_link_idx !== '0 || out_link_val !== '0 ||
            out_misalign !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: actual v=%0b npc=%h lval=%h expected all zero",
                     out_valid, out_next_pc, out_link_val);
        end
        rst_n = 1'b1;

        drive(1, 3'd1, 32'h0000_1000, 32'h0,         32'h20,        "R2 beqz taken");
        drive(1, 3'd1, 32'h0000_1000, 32'h0,         32'hFFFF_FFF8, "R2 beqz negative offset");
        drive(1, 3'd1, 32'h0000_1000, 32'h5,         32'h20,        "R4 beqz not taken");
        drive(1, 3'd2, 32'h0000_2000, 32'h8000_0000, 32'h40,        "R3 bnez top bit");
        drive(1, 3'd2, 32'h0000_2000, 32'h0,         32'h40,        "R4 bnez not taken");
        drive(1, 3'd1, 32'hFFFF_FFFE, 32'h1,         32'h10,        "R4 sequential wrap");
        drive(1, 3'd4, 32'h0000_2000, 32'h0,         32'hFFFF_FF00, "R5 jal");
        drive(1, 3'd3, 32'h0000_2000, 32'h0,         32'h0000_0100, "R6 j no link");
        drive(1, 3'd5, 32'h0000_0500, 32'h0000_3001, 32'h0,         "R7 jr odd source");
        drive(1, 3'd6, 32'h0000_0600, 32'h0000_4003, 32'h0,         "R8 jalr odd source");
        drive(1, 3'd0, 32'h0000_0700, 32'h0,         32'h80,        "R9 op none");
        drive(1, 3'd7, 32'h0000_0700, 32'h0,         32'h80,        "R9 op reserved");
        drive(0, 3'd4, 32'h0000_0800, 32'h0,         32'h80,        "R9 invalid jal");
        drive(1, 3'd4, 32'h0000_0100, 32'h0,         32'h11,        "R10 jal odd target");
        drive(1, 3'd1, 32'h0000_0100, 32'h0,         32'h13,        "R10 beqz odd taken");
        drive(1, 3'd1, 32'h0000_0100, 32'h9,         32'h13,        "R10 beqz odd not taken");
        drive(1, 3'd5, 32'h0000_0100, 32'h0000_0777, 32'h0,         "R10 jr no flag");
        drive(1, 3'd6, 32'h0000_0200, 32'h0000_0001, 32'h0,         "R11 back-to-back jalr");
        drive(1, 3'd2, 32'h0000_0300, 32'h1,         32'h4,         "R11 back-to-back bnez");
        drive(0, 3'd0, 32'h0000_0400, 32'h0,         32'h0,         "R11 valid drops");

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule